// File: doc/BRIEF.md
# Blind Two-Wire Bias DAC Write Encoder

This block turns one request into a complete two-wire write toward a bias DAC whose clock and data lines are driven as bits of a single control register. That register can only be written, one serial frame at a time. The block does not toggle pins. It emits a list of whole-register writes, and a downstream serializer shifts each write out as an 8-bit frame. Every frame carries the register address in its top three bits. The low five bits carry the register image: the line clock in bit 0, the line data in bit 1, and three caller-supplied bits in bits 4:2. Those three bits are held constant through the whole transaction, so that neighbouring supply controls in the same register keep their state.

One transaction is a start condition, then the fixed preamble byte 0x9C, then the fixed sub-address byte 0x00, then the caller's data byte, then a stop condition. Each of the three bytes is followed by one acknowledge slot. The line is write-only, so an acknowledge slot is a blind clock pulse with data held low and nothing is read back. After each accepted write the block stays quiet for a configurable settling gap before it offers the next one. That gap lets the line settle at the slow pace the DAC expects.

Top module: `dac_bitbang_encoder`

## Requirements
- R1: After a synchronous active-low reset, `frm_valid_o`, `busy_o` and `done_o` are low, and a transaction in progress is abandoned.
- R2: A high `trig_i` sampled while idle latches `data_i` and `base_i`. From the next cycle `busy_o` and `frm_valid_o` are high.
- R3: Every frame has the value 3 in bits 7:5, `base_i[4:2]` as latched at the trigger in bits 4:2, line data in bit 1 and line clock in bit 0. `base_i[1:0]` has no effect.
- R4: The transaction opens with three writes whose {data,clock} pairs are {1,1}, {0,1}, {0,0}.
- R5: Every data bit takes three writes: {d,0}, {d,1}, {d,0}. Bits go most significant first. The bytes go in this order: 0x9C, 0x00, then the latched data byte.
- R6: Each byte is followed by an acknowledge slot of three writes, {0,0}, {0,1}, {0,0}. The slot never depends on any input.
- R7: The transaction closes with three writes whose {data,clock} pairs are {0,0}, {0,1}, {1,1}.
- R8: A transaction consists of exactly 87 accepted writes. No further frame is offered afterwards.
- R9: While `frm_valid_o` is high and `frm_ready_i` is low, the frame is held unchanged.
- R10: After each accepted write other than the last, `frm_valid_o` stays low for exactly GAP_CYCLES cycles and then rises with the next write.
- R11: `busy_o` stays high until the final write is accepted. In the cycle after that acceptance, `busy_o` is low and `done_o` is high for one cycle.
- R12: While busy, `trig_i`, `data_i` and `base_i` have no effect on the writes that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Starts a transaction when idle |
| data_i | input | 8 | Value written to the DAC as the third byte |
| base_i | input | 5 | Register image; bits 4:2 are kept in every frame |
| frm_valid_o | output | 1 | A register write is offered |
| frm_ready_i | input | 1 | The serializer takes the offered write |
| frm_data_o | output | 8 | Frame: address in 7:5, register image in 4:0 |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse after the final write is accepted |

## Verification
A trigger seen at a clock edge makes `busy_o` and the first frame visible right after that edge. An accepted write removes `frm_valid_o` right after its edge, and the next frame appears exactly GAP_CYCLES cycles later. The final acceptance turns into `done_o` with `busy_o` low one edge later, and the pulse is gone after the following edge. The bench drives and samples only on the falling edge, so each result is read at the first falling edge after the rising edge that produces it. It counts idle falling edges between frames to check the gap to the cycle. Back-pressure is applied for a fixed number of falling edges per frame, and the held frame is compared on each of them.

// File: rtl/bbe_pkg.sv
// Package bbe_pkg
// Shared types and derived counts for the blind two-wire write encoder.
// Assumes one start slot, three bytes each followed by an acknowledge slot,
// and one stop slot, with three register writes per slot.
package bbe_pkg;

    localparam int BYTE_W         = 8;
    localparam int STEPS_PER_SLOT = 3;
    localparam int SLOTS_PER_BYTE = BYTE_W + 1;          // data bits plus ack
    localparam int BYTES_PER_TXN  = 3;
    localparam int WRITES_PER_TXN =
        2 * STEPS_PER_SLOT + BYTES_PER_TXN * SLOTS_PER_BYTE * STEPS_PER_SLOT;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_SEND,
        CTL_GAP
    } ctl_state_t;

    typedef enum logic [2:0] {
        SEG_START,
        SEG_PREAMBLE,
        SEG_SUBADDR,
        SEG_PAYLOAD,
        SEG_STOP
    } seg_t;

endpackage

// File: rtl/bbe_walker.sv
// Module bbe_walker
// Walks the position inside one transaction: segment, bit slot within a
// byte segment, and write step within the slot. Assumes `clear` and
// `advance` are never high together.
module bbe_walker
    import bbe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       advance,
    output seg_t       seg_o,
    output logic [3:0] slot_o,
    output logic [1:0] step_o,
    output logic       last_o
);

    localparam logic [1:0] LAST_STEP = 2'(STEPS_PER_SLOT - 1);
    localparam logic [3:0] LAST_SLOT = 4'(SLOTS_PER_BYTE - 1);

    seg_t       seg_q;
    logic [3:0] slot_q;
    logic [1:0] step_q;
    logic       byte_seg;

    // Purpose: mark segments that carry a byte and its acknowledge slot.
    always_comb begin
        byte_seg = (seg_q == SEG_PREAMBLE) || (seg_q == SEG_SUBADDR) ||
                   (seg_q == SEG_PAYLOAD);
    end

    // Purpose: step through writes, slots and segments in transmit order.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seg_q  <= SEG_START;
            slot_q <= '0;
            step_q <= '0;
        end else if (advance) begin
            if (step_q != LAST_STEP) begin
                step_q <= step_q + 2'd1;
            end else begin
                step_q <= '0;
                if (byte_seg && slot_q != LAST_SLOT) begin
                    slot_q <= slot_q + 4'd1;
                end else begin
                    slot_q <= '0;
                    case (seg_q)
                        SEG_START:    seg_q <= SEG_PREAMBLE;
                        SEG_PREAMBLE: seg_q <= SEG_SUBADDR;
                        SEG_SUBADDR:  seg_q <= SEG_PAYLOAD;
                        SEG_PAYLOAD:  seg_q <= SEG_STOP;
                        default:      seg_q <= SEG_START;
                    endcase
                end
            end
        end
    end

    assign seg_o  = seg_q;
    assign slot_o = slot_q;
    assign step_o = step_q;
    assign last_o = (seg_q == SEG_STOP) && (step_q == LAST_STEP);

    a_r8_walk_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q <= LAST_STEP) && (slot_q <= LAST_SLOT));

    // R5: bit slots advance by one, most significant first, inside a byte
    a_r5_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && byte_seg && step_q == LAST_STEP && slot_q != LAST_SLOT)
        |=> (slot_q == $past(slot_q) + 4'd1));

endmodule

// File: rtl/bbe_gap_timer.sv
// Module bbe_gap_timer
// Counts the settling gap after an accepted write. A load starts a count of
// GAP_CYCLES cycles; `expired_o` is high in the last of them. Assumes
// GAP_CYCLES >= 1.
module bbe_gap_timer #(
    parameter int GAP_CYCLES = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired_o
);

    localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(GAP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: load on acceptance, then count down to zero and rest there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R10: once loaded the count only decreases, one per cycle
    a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/bbe_frame_map.sv
// Module bbe_frame_map
// Maps a transaction position to the 8-bit register-write frame. The result
// is purely combinational. Assumes the latched base bits and data byte are
// stable for the whole transaction.
module bbe_frame_map
    import bbe_pkg::*;
#(
    parameter int          ADDR_W   = 3,
    parameter int          PAY_W    = 5,
    parameter int          REG_ADDR = 3,
    parameter logic [7:0]  PRE_BYTE = 8'h9C,
    parameter logic [7:0]  SUB_BYTE = 8'h00
) (
    input  seg_t                    seg,
    input  logic [3:0]              slot,
    input  logic [1:0]              step,
    input  logic [BYTE_W-1:0]       data_byte,
    input  logic [PAY_W-3:0]        base_hi,
    output logic [ADDR_W+PAY_W-1:0] frame_o
);

    logic              line_clk;
    logic              line_dat;
    logic [BYTE_W-1:0] cur_byte;

    // Purpose: choose the byte carried by the current segment.
    always_comb begin
        case (seg)
            SEG_PREAMBLE: cur_byte = PRE_BYTE;
            SEG_SUBADDR:  cur_byte = SUB_BYTE;
            default:      cur_byte = data_byte;
        endcase
    end

    // Purpose: derive the clock and data line levels for this write.
    always_comb begin
        case (seg)
            SEG_START: begin
                line_clk = (step != 2'd2);
                line_dat = (step == 2'd0);
            end
            SEG_STOP: begin
                line_clk = (step != 2'd0);
                line_dat = (step == 2'd2);
            end
            default: begin
                line_clk = (step == 2'd1);
                line_dat = (slot == 4'(BYTE_W)) ? 1'b0 : cur_byte[3'd7 - slot[2:0]];
            end
        endcase
    end

    assign frame_o = {ADDR_W'(REG_ADDR), base_hi, line_dat, line_clk};

endmodule

// File: rtl/dac_bitbang_encoder.sv
// Module dac_bitbang_encoder (top)
// Issues the 87 register writes of a blind two-wire DAC write, one at a time
// over a valid/ready handshake, with a settling gap after each accepted
// write. Assumes the downstream serializer accepts a write at most once per
// cycle while frm_valid_o is high.
module dac_bitbang_encoder
    import bbe_pkg::*;
#(
    parameter int         GAP_CYCLES = 1250,
    parameter int         REG_ADDR   = 3,
    parameter logic [7:0] PRE_BYTE   = 8'h9C,
    parameter logic [7:0] SUB_BYTE   = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic [7:0] data_i,
    input  logic [4:0] base_i,
    output logic       frm_valid_o,
    input  logic       frm_ready_i,
    output logic [7:0] frm_data_o,
    output logic       busy_o,
    output logic       done_o
);

    localparam int ADDR_W = 3;
    localparam int PAY_W  = 5;

    ctl_state_t        state_q;
    logic              done_q;
    logic [BYTE_W-1:0] data_q;
    logic [PAY_W-3:0]  base_q;

    seg_t       seg;
    logic [3:0] slot;
    logic [1:0] step;
    logic       last;
    logic       gap_done;
    logic       accept;
    logic       launch;

    assign launch = (state_q == CTL_IDLE) && trig_i;
    assign accept = (state_q == CTL_SEND) && frm_ready_i;

    bbe_walker i_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .advance (accept),
        .seg_o   (seg),
        .slot_o  (slot),
        .step_o  (step),
        .last_o  (last)
    );

    bbe_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) i_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && !last),
        .expired_o (gap_done)
    );

    bbe_frame_map #(
        .ADDR_W   (ADDR_W),
        .PAY_W    (PAY_W),
        .REG_ADDR (REG_ADDR),
        .PRE_BYTE (PRE_BYTE),
        .SUB_BYTE (SUB_BYTE)
    ) i_map (
        .seg       (seg),
        .slot      (slot),
        .step      (step),
        .data_byte (data_q),
        .base_hi   (base_q),
        .frame_o   (frm_data_o)
    );

    // Purpose: sequence idle, offer and settling gap; latch inputs at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
            done_q  <= 1'b0;
            data_q  <= '0;
            base_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                CTL_IDLE: begin
                    if (trig_i) begin
                        data_q  <= data_i;
                        base_q  <= base_i[PAY_W-1:2];
                        state_q <= CTL_SEND;
                    end
                end
                CTL_SEND: begin
                    if (frm_ready_i) begin
                        if (last) begin
                            state_q <= CTL_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= CTL_GAP;
                        end
                    end
                end
                CTL_GAP: begin
                    if (gap_done) state_q <= CTL_SEND;
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

    assign frm_valid_o = (state_q == CTL_SEND);
    assign busy_o      = (state_q != CTL_IDLE);
    assign done_o      = done_q;

    a_r9_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_o && !frm_ready_i) |=> (frm_valid_o && $stable(frm_data_o)));

    a_r10_quiet_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_o && frm_ready_i) |=> !frm_valid_o);

    a_r11_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(frm_valid_o && frm_ready_i)));

    a_r2_busy_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(trig_i));

    a_r12_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(data_q) && $stable(base_q)));

endmodule

// File: tb/test_dac_bitbang_encoder.sv
module test_dac_bitbang_encoder;

    localparam int GAP    = 3;
    localparam int NWR    = 87;
    localparam int NVEC   = 5;
    // vector: [15:8] data byte, [7:3] base bits, [2:0] back-pressure cycles
    localparam logic [15:0] VEC [NVEC] = '{
        {8'hA5, 5'b10100, 3'd0},
        {8'hFF, 5'b11111, 3'd1},
        {8'h00, 5'b00000, 3'd2},
        {8'h7D, 5'b01011, 3'd3},
        {8'h80, 5'b11000, 3'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic [4:0] base_i = 5'h00;
    logic       frm_valid_o;
    logic       frm_ready_i = 1'b0;
    logic [7:0] frm_data_o;
    logic       busy_o;
    logic       done_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;   // 125 MHz

    dac_bitbang_encoder #(.GAP_CYCLES(GAP)) i_dac_bitbang_encoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_i),
        .data_i      (data_i),
        .base_i      (base_i),
        .frm_valid_o (frm_valid_o),
        .frm_ready_i (frm_ready_i),
        .frm_data_o  (frm_data_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected frame for write index idx, built from R3..R7
    function automatic logic [7:0] exp_frame(input int idx, input logic [7:0] d,
                                             input logic [4:0] b);
        logic ck, dt;
        logic [7:0] byt;
        int k, sl, st;
        if (idx < 3) begin
            ck = (idx != 2); dt = (idx == 0);
        end else if (idx >= NWR - 3) begin
            st = idx - (NWR - 3);
            ck = (st != 0); dt = (st == 2);
        end else begin
            k   = idx - 3;
            byt = (k / 27 == 0) ? 8'h9C : (k / 27 == 1) ? 8'h00 : d;
            sl  = (k % 27) / 3;
            st  = k % 3;
            ck  = (st == 1);
            dt  = (sl == 8) ? 1'b0 : byt[7 - sl];
        end
        return {3'd3, b[4:2], dt, ck};
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // one transaction; inject=1 pulses a trigger with new inputs mid-way (R12)
    task automatic run_txn(input logic [7:0] d, input logic [4:0] b,
                           input int stall, input bit inject, input string tag);
        int n = 0, idle_run = 0, wait_left = stall, guard = 0;
        int bad_frm = 0, bad_gap = 0, bad_hold = 0, bad_busy = 0;
        int first_bad = -1;
        bit fresh = 0, stalled = 0;
        logic [7:0] held = '0;
        @(negedge clk);
        data_i = d; base_i = b; trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0; data_i = ~d; base_i = ~b;
        // R2: busy and first frame visible after the trigger edge
        check(busy_o && frm_valid_o, {tag, " R2 launch"}, {busy_o, frm_valid_o}, 2'b11);
        while (n < NWR && guard < 2000) begin
            guard++;
            if (guard > 1) @(negedge clk);
            trig_i = (inject && n == 40) ? 1'b1 : 1'b0;
            if (!busy_o) bad_busy++;
            if (frm_valid_o) begin
                if (fresh && idle_run != GAP) bad_gap++;
                fresh = 0;
                if (stalled && frm_data_o != held) bad_hold++;
                if (wait_left > 0) begin
                    frm_ready_i = 1'b0; wait_left--; stalled = 1; held = frm_data_o;
                end else begin
                    frm_ready_i = 1'b1;
                    if (frm_data_o != exp_frame(n, d, b)) begin
                        bad_frm++;
                        if (first_bad < 0) first_bad = n;
                    end
                    n++; wait_left = stall; stalled = 0; idle_run = 0; fresh = 1;
                end
            end else begin
                frm_ready_i = 1'b0;
                if (stalled) bad_hold++;
                stalled = 0;
                idle_run++;
            end
        end
        @(negedge clk);
        frm_ready_i = 1'b0; trig_i = 1'b0;
        // R3 R4 R5 R6 R7: every accepted write matches the expected image
        check(bad_frm == 0, {tag, " R3/R4/R5/R6/R7 frames"}, first_bad, -1);
        check(n == NWR, {tag, " R8 write count"}, n, NWR);
        check(bad_gap == 0, {tag, " R10 gap"}, bad_gap, 0);
        check(bad_hold == 0, {tag, " R9 hold"}, bad_hold, 0);
        check(bad_busy == 0, {tag, " R11 busy during"}, bad_busy, 0);
        check(done_o && !busy_o && !frm_valid_o, {tag, " R11 done pulse"},
              {done_o, busy_o, frm_valid_o}, 3'b100);
        @(negedge clk);
        check(!done_o, {tag, " R11 done one cycle"}, done_o, 0);
        repeat (GAP + 2) @(negedge clk);
        check(!frm_valid_o && !busy_o, {tag, " R8 no extra frame"},
              {frm_valid_o, busy_o}, 2'b00);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!frm_valid_o && !busy_o && !done_o, "R1 reset state",
              {frm_valid_o, busy_o, done_o}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_txn(VEC[i][15:8], VEC[i][7:3], int'(VEC[i][2:0]), 1'b0, $sformatf("vec%0d", i));
        end

        // R12: trigger and new inputs during a transaction change nothing
        run_txn(8'h3C, 5'b10001, 1, 1'b1, "r12_retrigger");

        // R1: reset during a transaction abandons it
        @(negedge clk);
        data_i = 8'h55; base_i = 5'b00100; trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0; frm_ready_i = 1'b1;
        repeat (20) @(negedge clk);
        frm_ready_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!frm_valid_o && !busy_o && !done_o, "R1 mid-run reset",
              {frm_valid_o, busy_o, done_o}, 3'b000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!frm_valid_o && !busy_o, "R1 stays idle", {frm_valid_o, busy_o}, 2'b00);

        // a fresh run after the abandoned one starts from the opening write
        run_txn(8'hC3, 5'b01100, 0, 1'b0, "post_reset");
        finish_run();
    end

endmodule